// File: doc/BRIEF.md
# Fully Associative Translation Cache with Walker Refill

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. It holds a small, fully associative set of page mappings. Each mapping has a 20-bit virtual page number, a physical frame number and a valid flag. A lookup compares the page number of the incoming address with every valid mapping at once. On a hit, the physical address is returned in the same cycle as the request is accepted, and no page-table access is made.

On a miss, the block keeps the address internally and lowers its request-ready signal. It then asks an external page-table walker for the frame. When the walker returns a frame, the block writes the new mapping into the cache and then answers the original lookup. When the walker reports that the page is not present, the lookup ends with a fault and the cache is left unchanged. Once software has serviced the fault, a repeated lookup goes through the normal refill path.

A flush input clears every mapping in one cycle, and a single-page invalidate input removes the mapping of one page. The requester uses a valid/ready handshake. Responses come back in request order, as a valid-only pulse with the physical address and a fault flag.

The control is a three-state machine. LOOKUP accepts requests and answers hits. The MISS transition goes from LOOKUP to REFILL. REFILL holds the walker request, and the WALK_DONE transition leaves it when the walker responds. REPLY presents the refilled or faulted result for one cycle and returns to LOOKUP through the REPLY_DONE transition. A hit keeps the machine in LOOKUP.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `walk_req_valid` is 0, and no entry is valid, so the first lookup of any page misses.
- R2: When the page of an accepted request (`vaddr[31:12]`) matches a valid entry, `resp_valid` is 1 in the same cycle. `resp_paddr` is that entry's frame number in bits [31:12], joined with the unchanged offset `vaddr[11:0]`. `resp_fault` is 0, and no walker request is raised.
- R3: On a miss, `walk_req_valid` rises in the next cycle carrying the missing page number. It stays high, with a stable page number, until `walk_rsp_valid`. `req_ready` is 0 for the whole refill. The response comes one cycle after `walk_rsp_valid`, with `resp_paddr = {walk_rsp_pfn, offset}`.
- R4: A successful refill installs the mapping, so a later lookup of the same page hits without a walker request.
- R5: A walker response with `walk_rsp_fault = 1` produces `resp_valid` with `resp_fault = 1` and installs nothing. A repeated lookup of that page walks again, and once the walker succeeds the mapping is installed as in R4.
- R6: A refill writes the lowest-numbered invalid entry. When every entry is valid, it writes the entry named by a round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping) only on such an eviction, and does not move when an invalid entry is used.
- R7: A one-cycle pulse on `flush_all` clears every valid flag by the next cycle.
- R8: A one-cycle pulse on `inval_en` clears the entry holding page `inval_vpn` and leaves every other entry unchanged.
- R9: No two valid entries ever hold the same page number; a refill for a page already present rewrites that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup (LOOKUP state) |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Translation result present |
| resp_paddr | output | 32 | Physical address (frame and offset) |
| resp_fault | output | 1 | Lookup ended in a page fault |
| walk_req_valid | output | 1 | Refill request to the walker, held until answered |
| walk_req_vpn | output | 20 | Page number to be walked |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_pfn | input | 20 | Frame number from the walker |
| walk_rsp_fault | input | 1 | Walker found the page not present |
| flush_all | input | 1 | Clear all entries |
| inval_en | input | 1 | Clear the entry of one page |
| inval_vpn | input | 20 | Page number to invalidate |

## Verification
Lookups are issued as cold misses, as repeated hits on one page with offsets at both ends of the page, and as hits that alternate between pages. Together these separate the frame/offset join from the hit/miss decision. A page that faults on the walker is looked up twice before it is serviced, which shows whether a faulting walk pollutes the cache. A flush and a single-page invalidate are each followed by lookups of both the cleared pages and the surviving pages. The cache is then filled past capacity, and the choice of victim is inferred from which pages later miss. This is done with and without an invalid hole, so that the round-robin order can be told apart from free-slot reuse.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Controller states
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_REFILL = 2'd1,
        ST_REPLY  = 2'd2
    } tlb_state_e;

    localparam int unsigned PAGE_OFS_W  = 12;
    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_PFN_W   = 20;
    localparam int unsigned DEF_ENTRIES = 16;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PFN_W   = 20,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   key_vpn,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PFN_W-1:0]   hit_pfn,
    output logic [ENTRIES-1:0] valid_vec,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic               flush,
    input  logic               inval_en,
    input  logic [VPN_W-1:0]   inval_vpn
);
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] valid_d;
    logic [ENTRIES-1:0] match;

    // Parallel compare against every entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == key_vpn);

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                vpn_q[g] <= wr_vpn;
                pfn_q[g] <= wr_pfn;
            end
        end

        // R8: a matching, not-rewritten entry is gone next cycle
        AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (inval_en && valid_q[g] && (vpn_q[g] == inval_vpn) &&
             !(wr_en && (wr_idx == IDX_W'(g))))
            |=> !valid_q[g]); // R8
    end

    // One-hot to index/frame reduction
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
                hit_pfn = hit_pfn | pfn_q[i];
            end
        end
    end

    // Valid flags: install first, then invalidations take priority
    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
        if (inval_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (((wr_en && (wr_idx == IDX_W'(i))) ? wr_vpn : vpn_q[i]) == inval_vpn)
                    valid_d[i] = 1'b0;
            end
        end
        if (flush) valid_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    assign valid_vec = valid_q;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R7
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && !(inval_en && (inval_vpn == wr_vpn)))
        |=> valid_q[$past(wr_idx)]); // R4
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               any_free
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    // Lowest-numbered invalid entry
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (take && !any_free) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

    assign victim_idx = any_free ? free_idx : rr_q;

    AST_FREE_SLOT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !valid_vec[victim_idx]); // R6
    AST_RR_HOLDS_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && any_free) |=> $stable(rr_q)); // R6
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PFN_W  = 20,
    localparam int unsigned VA_W  = VPN_W + PAGE_OFS_W,
    localparam int unsigned PA_W  = PFN_W + PAGE_OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic             walk_rsp_fault,
    input  logic             lk_hit,
    input  logic [PFN_W-1:0] lk_pfn,
    output logic [VPN_W-1:0] key_vpn,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn
);
    tlb_state_e state_q, state_d;

    logic [VA_W-1:0]  pend_va_q;
    logic [PFN_W-1:0] pend_pfn_q;
    logic             pend_fault_q;

    wire [VPN_W-1:0]      req_vpn  = req_vaddr[VA_W-1:PAGE_OFS_W];
    wire [PAGE_OFS_W-1:0] req_ofs  = req_vaddr[PAGE_OFS_W-1:0];
    wire [VPN_W-1:0]      pend_vpn = pend_va_q[VA_W-1:PAGE_OFS_W];
    wire [PAGE_OFS_W-1:0] pend_ofs = pend_va_q[PAGE_OFS_W-1:0];

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (req_valid && !lk_hit) state_d = ST_REFILL;
            ST_REFILL: if (walk_rsp_valid)       state_d = ST_REPLY;
            ST_REPLY:                             state_d = ST_LOOKUP;
            default:                              state_d = ST_LOOKUP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // Pending request and walker result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_va_q    <= '0;
            pend_pfn_q   <= '0;
            pend_fault_q <= 1'b0;
        end else begin
            if (state_q == ST_LOOKUP && req_valid && !lk_hit)
                pend_va_q <= req_vaddr;
            if (state_q == ST_REFILL && walk_rsp_valid) begin
                pend_pfn_q   <= walk_rsp_pfn;
                pend_fault_q <= walk_rsp_fault;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        resp_valid     = 1'b0;
        resp_paddr     = {pend_pfn_q, pend_ofs};
        resp_fault     = 1'b0;
        walk_req_valid = 1'b0;
        key_vpn        = pend_vpn;
        fill_en        = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                req_ready  = 1'b1;
                key_vpn    = req_vpn;
                resp_valid = req_valid && lk_hit;
                resp_paddr = {lk_pfn, req_ofs};
            end
            ST_REFILL: begin
                walk_req_valid = 1'b1;
                fill_en        = walk_rsp_valid && !walk_rsp_fault;
            end
            ST_REPLY: begin
                resp_valid = 1'b1;
                resp_fault = pend_fault_q;
            end
            default: ;
        endcase
    end

    assign walk_req_vpn = pend_vpn;
    assign fill_vpn     = pend_vpn;
    assign fill_pfn     = walk_rsp_pfn;

    AST_NO_ACCEPT_DURING_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready); // R3
    AST_WALK_VPN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && $past(walk_req_valid)) |-> $stable(walk_req_vpn)); // R3
    AST_REPLY_FOLLOWS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid) |=> (resp_valid && !req_ready)); // R3
    AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_rsp_valid && walk_rsp_fault) |-> !fill_en); // R5
    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> !walk_req_valid); // R2
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned VA_W   = VPN_W + PAGE_OFS_W,
    localparam int unsigned PA_W   = PFN_W + PAGE_OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic             walk_rsp_fault,
    input  logic             flush_all,
    input  logic             inval_en,
    input  logic [VPN_W-1:0] inval_vpn
);
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic [PFN_W-1:0]   lk_pfn;
    logic [ENTRIES-1:0] valid_vec;
    logic [VPN_W-1:0]   key_vpn;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [PFN_W-1:0]   fill_pfn;
    logic [IDX_W-1:0]   victim_idx;
    logic               any_free;
    logic [IDX_W-1:0]   fill_idx;
    logic               take_victim;

    // An already-present page is rewritten in place (keeps pages unique)
    assign fill_idx    = lk_hit ? lk_idx : victim_idx;
    assign take_victim = fill_en && !lk_hit;

    tlb_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_fault(walk_rsp_fault),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .key_vpn(key_vpn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) array_i (
        .clk(clk), .rst_n(rst_n),
        .key_vpn(key_vpn), .hit(lk_hit), .hit_idx(lk_idx), .hit_pfn(lk_pfn),
        .valid_vec(valid_vec),
        .wr_en(fill_en), .wr_idx(fill_idx), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
        .flush(flush_all), .inval_en(inval_en), .inval_vpn(inval_vpn)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES)) victim_i (
        .clk(clk), .rst_n(rst_n),
        .valid_vec(valid_vec), .take(take_victim),
        .victim_idx(victim_idx), .any_free(any_free)
    );
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic [19:0] walk_rsp_pfn = '0;
    logic        walk_rsp_fault = 1'b0;
    logic        flush_all = 1'b0;
    logic        inval_en = 1'b0;
    logic [19:0] inval_vpn = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_fault(walk_rsp_fault),
        .flush_all(flush_all), .inval_en(inval_en), .inval_vpn(inval_vpn)
    );

    typedef struct {
        logic [19:0] vpn;
        logic [11:0] ofs;
        bit          miss;
        bit          fault;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          walk_count = 0;
    logic [19:0] last_walk_vpn = '0;
    logic [19:0] fault_vpn = 20'hFFFFF;
    bit          finished = 1'b0;

    function automatic logic [19:0] frame_of(input logic [19:0] vpn);
        return vpn ^ 20'h5A5A5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: push expectation, then present request until accepted
    task automatic lookup(input logic [19:0] vpn, input logic [11:0] ofs,
                          input bit miss, input bit fault, input string tag);
        exp_t e;
        e.vpn = vpn; e.ofs = ofs; e.miss = miss; e.fault = fault; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_vaddr = {vpn, ofs};
        #(CLK_PERIOD/4);
        while (!req_ready) begin
            @(negedge clk);
            #(CLK_PERIOD/4);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Walker model
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (walk_req_valid) begin
                int lat;
                walk_count++;
                last_walk_vpn = walk_req_vpn;
                check(!req_ready, "R3", "ready low during refill", {31'd0, req_ready}, 32'd0);
                lat = 1 + int'(walk_req_vpn[1:0]);
                repeat (lat) @(negedge clk);
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = (last_walk_vpn == fault_vpn);
                walk_rsp_pfn   = frame_of(last_walk_vpn);
                @(negedge clk);
                walk_rsp_valid = 1'b0;
                walk_rsp_fault = 1'b0;
            end
        end
    end

    // Monitor: pop and compare every response
    initial begin
        int seen_walks;
        seen_walks = 0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && resp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", resp_paddr, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(resp_fault == e.fault, e.tag, "fault flag",
                          {31'd0, resp_fault}, {31'd0, e.fault});
                    if (!e.fault)
                        check(resp_paddr == {frame_of(e.vpn), e.ofs}, e.tag, "paddr",
                              resp_paddr, {frame_of(e.vpn), e.ofs});
                    check((walk_count - seen_walks) == (e.miss ? 1 : 0), e.tag,
                          "walker requests", 32'(walk_count - seen_walks),
                          e.miss ? 32'd1 : 32'd0);
                    if (e.miss)
                        check(last_walk_vpn == e.vpn, e.tag, "walked page",
                              {12'd0, last_walk_vpn}, {12'd0, e.vpn});
                    seen_walks = walk_count;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        check(req_ready == 1'b0 || req_ready == 1'b1, "R1", "ready known in reset",
              {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        check(resp_valid == 1'b0, "R1", "no response after reset", {31'd0, resp_valid}, 32'd0);
        check(walk_req_valid == 1'b0, "R1", "no walk after reset", {31'd0, walk_req_valid}, 32'd0);

        // R1/R3 cold miss, then R2/R4 hits at both offset ends
        lookup(20'h12345, 12'h004, 1, 0, "R1");
        lookup(20'h12345, 12'hFFF, 0, 0, "R4");
        lookup(20'h12345, 12'h000, 0, 0, "R2");

        // R5: fault twice (nothing installed), then serviced
        fault_vpn = 20'h00777;
        lookup(20'h00777, 12'h010, 1, 1, "R5");
        lookup(20'h00777, 12'h020, 1, 1, "R5");
        wait_idle();
        fault_vpn = 20'hFFFFF;
        lookup(20'h00777, 12'h030, 1, 0, "R5");
        lookup(20'h00777, 12'h040, 0, 0, "R5");
        lookup(20'h12345, 12'h123, 0, 0, "R2");
        wait_idle();

        // R7: flush clears everything
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
        lookup(20'h12345, 12'h001, 1, 0, "R7");   // entry 0
        lookup(20'h00777, 12'h002, 1, 0, "R7");   // entry 1
        wait_idle();

        // R8: single-page invalidate
        @(negedge clk); inval_en = 1'b1; inval_vpn = 20'h12345;
        @(negedge clk); inval_en = 1'b0;
        lookup(20'h00777, 12'h003, 0, 0, "R8");
        lookup(20'h12345, 12'h004, 1, 0, "R8");   // refills entry 0

        // R6: fill entries 2..15 with 0x100..0x10D
        for (int k = 0; k < 14; k++)
            lookup(20'h00100 + 20'(k), 12'h0AA, 1, 0, "R6");
        lookup(20'h00200, 12'h0BB, 1, 0, "R6");   // evicts entry 0 (0x12345)
        lookup(20'h00777, 12'h0CC, 0, 0, "R6");
        lookup(20'h0010D, 12'h0CC, 0, 0, "R6");
        lookup(20'h12345, 12'h0DD, 1, 0, "R6");   // evicts entry 1 (0x777)
        lookup(20'h00777, 12'h0EE, 1, 0, "R6");   // evicts entry 2 (0x100)
        lookup(20'h00200, 12'h001, 0, 0, "R6");
        lookup(20'h12345, 12'h002, 0, 0, "R6");
        lookup(20'h00101, 12'h003, 0, 0, "R6");
        lookup(20'h00100, 12'h004, 1, 0, "R6");   // evicts entry 3 (0x101)
        wait_idle();

        // R6: invalid hole is used first and the pointer stays at 4
        @(negedge clk); inval_en = 1'b1; inval_vpn = 20'h00105;
        @(negedge clk); inval_en = 1'b0;
        lookup(20'h00300, 12'h005, 1, 0, "R6");   // fills entry 7
        lookup(20'h00400, 12'h006, 1, 0, "R6");   // evicts entry 4 (0x102)
        lookup(20'h00103, 12'h007, 0, 0, "R6");
        lookup(20'h00300, 12'h008, 0, 0, "R6");
        lookup(20'h00106, 12'h009, 0, 0, "R8");
        lookup(20'h00102, 12'h00A, 1, 0, "R6");
        wait_idle();

        check(sb_q.size() == 0, "R3", "all responses received", 32'(sb_q.size()), 32'd0);
        finish_test();
    end
endmodule